// File: doc/BRIEF.md
# Serial Clock-Calendar Register Port

This block is the bus-facing half of a battery-backed clock/calendar. It is a two-wire serial slave that answers at the 7-bit address 1101000. It holds a pointer into a ten-location register space. Locations 00h–06h are time and date. 07h is control, 08h selects the charge path of a backup cell, and 09h holds the oscillator-stop status flag. The time counters themselves live in a separate calendar module. This block reads them through a parallel bus into a seven-byte user snapshot. It writes them through one load strobe per field plus a shared data byte, so a host always reads a coherent time while the counters keep running.

The host writes the address with R/W = 0. The first data byte then sets the pointer, and every later byte is stored at the pointer, which then advances. A read (R/W = 1) starts wherever the pointer was left. The pointer wraps from 07h to 00h, so a block read of the clock never strays into the charger or flag locations. Those two locations are reached only by loading the pointer, and the pointer wraps from 09h to 00h. The snapshot is refreshed on every START, on every STOP, and whenever the pointer steps to 00h. A write to the seconds location or to the control location also pulses a divider-reset output in the cycle its byte is acknowledged.

The bit-level engine is a state machine with these states:
- `S_IDLE`: waiting for START.
- `S_ADDR`: shifting in the address byte.
- `S_ADDR_ACK`: acknowledging the address.
- `S_WR_BYTE`: shifting in a received byte.
- `S_WR_ACK`: acknowledging that byte.
- `S_RD_BYTE`: driving a byte out, MSB first.
- `S_RD_ACK`: sampling the host's acknowledge.

Its transitions are:
- START from any state goes to `S_ADDR`.
- STOP from any state goes to `S_IDLE`.
- From `S_ADDR`, on the SCL fall after the eighth bit, it goes to `S_ADDR_ACK` on an address match and to `S_IDLE` otherwise.
- From `S_ADDR_ACK`, on the next SCL fall, it goes to `S_RD_BYTE` or `S_WR_BYTE` according to R/W.
- From `S_WR_BYTE`, on the SCL fall after eight bits, it goes to `S_WR_ACK`, and back to `S_WR_BYTE` on the following fall.
- From `S_RD_BYTE`, on the eighth SCL fall, it goes to `S_RD_ACK`.
- From `S_RD_ACK`, on the next fall, it goes to `S_RD_BYTE` if the host acknowledged and to `S_IDLE` on a NACK.

Top module: `rtc_i2c_regif`

## Requirements
- R1: The block acknowledges only the address byte 1101000 followed by R/W. After any other address it acknowledges no byte and changes no register until the next START.
- R2: In a write, the first byte after the address loads the pointer. The pointer advances by one after each data byte written or read, and a read begins at the pointer left by the previous transfer.
- R3: When the pointer advances, 07h goes to 00h, 09h goes to 00h, and any value above 09h goes to 00h. Location 08h is entered only by a pointer load, and locations above 09h read as 00h.
- R4: Locations 00h–06h read from a snapshot of `time_rd`, where byte n is bits 8n+7:8n. The snapshot is taken at each START, at each STOP and when the pointer advances to 00h, and it does not follow `time_rd` at other times.
- R5: A byte written at location n (00h–06h) raises `time_ld[n]` for exactly one cycle, with the byte on `time_wdata` in that same cycle. No other strobe bit rises.
- R6: A byte written at 00h or at 07h gives exactly one one-cycle pulse on `div_rst`. Writes at other locations give none.
- R7: Flag location 09h reads as {flag, 0000000}. The flag is 1 after reset and is set by `osf_set`. Writing a byte with bit 7 = 0 clears it, writing bit 7 = 1 leaves it unchanged, and bits 6:0 ignore writes.
- R8: Charger location 08h resets to 00h and reads back as written. `charger_en` is 1 only when bits 7:4 = 1010, bits 3:2 are 01 or 10, and bits 1:0 are not 00. `diode_sel` is 1 when enabled and bits 3:2 = 10. `res_sel` equals bits 1:0 when enabled and 00 otherwise.
- R9: Control location 07h resets to 80h and reads back as written. Bit 7 drives `out_level`, bit 6 drives `ft_en`, bit 5 drives `cal_sign` and bits 4:0 drive `cal_mag`.
- R10: `sda_oe` (1 = pull SDA low) is asserted only while acknowledging a received byte and for 0-valued bits of a byte being read out. After a host NACK it stays released until the next START.
- R11: A START in the middle of a transfer (repeated START) restarts address reception without losing the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8× the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| time_rd | input | 8*TIME_BYTES | Live time/date bytes from the calendar, byte n at bits 8n+7:8n |
| osf_set | input | 1 | Oscillator-stop detector pulse, sets the flag |
| time_ld | output | TIME_BYTES | One-cycle load strobe per time/date field |
| time_wdata | output | 8 | Byte to load into the strobed field |
| div_rst | output | 1 | One-cycle divider-chain reset pulse |
| out_level | output | 1 | Static level for the test/output pin |
| ft_en | output | 1 | Selects the test frequency on that pin |
| cal_sign | output | 1 | Calibration direction |
| cal_mag | output | 5 | Calibration magnitude |
| charger_en | output | 1 | Charge path enabled |
| diode_sel | output | 1 | Series diode selected in the charge path |
| res_sel | output | 2 | Charge resistor code, 00 when disabled |

## Verification
On every cycle the assertions check several properties. The strobe vector is at most one-hot and `div_rst` never lasts two cycles. `osf_set` always leaves the flag set, and the pointer never steps from 07h to anything but 00h. The snapshot holds still when there is no START, STOP or pointer step, a START always lands in address reception, and SDA is never pulled while idle. Other behaviour can be shown only by the bench's bus transfers:
- the contents read back, and whether they reflect `time_rd` at the right moment across a rollover;
- the charger decode over several patterns;
- the flag's clear-only write;
- rejection of a foreign address;
- pointer retention across transfers and a repeated START.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_BYTE,
        S_WR_ACK,
        S_RD_BYTE,
        S_RD_ACK
    } i2c_state_e;

    localparam logic [7:0] CTRL_RESET  = 8'h80;
    localparam logic [7:0] TCS_RESET   = 8'h00;
    localparam logic [3:0] CHARGE_KEY  = 4'b1010;

endpackage

// File: rtl/rtc_i2c_sync.sv
module rtc_i2c_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_s;
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s    = scl_pipe[SYNC_STAGES-1];
    assign sda_s    = sda_pipe[SYNC_STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    // SDA edges while SCL stays high are bus conditions, not data
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/rtc_i2c_fsm.sv
module rtc_i2c_fsm
    import rtc_regif_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'b1101000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [7:0] tx_byte,
    output logic       sda_oe,
    output logic       wr_ev,
    output logic       wr_first,
    output logic [7:0] wr_data,
    output logic       rd_ev
);

    i2c_state_e state_q, state_d;
    logic [3:0] bitcnt_q;
    logic [7:0] shreg_q;
    logic [7:0] txreg_q;
    logic       rw_q;
    logic       first_q;
    logic       mack_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = S_ADDR;
        end else if (stop_ev) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:     state_d = S_IDLE;
                S_ADDR:     if (scl_fall && bitcnt_q == 4'd8)
                                state_d = (shreg_q[7:1] == SLV_ADDR) ? S_ADDR_ACK : S_IDLE;
                S_ADDR_ACK: if (scl_fall) state_d = rw_q ? S_RD_BYTE : S_WR_BYTE;
                S_WR_BYTE:  if (scl_fall && bitcnt_q == 4'd8) state_d = S_WR_ACK;
                S_WR_ACK:   if (scl_fall) state_d = S_WR_BYTE;
                S_RD_BYTE:  if (scl_fall && bitcnt_q == 4'd7) state_d = S_RD_ACK;
                S_RD_ACK:   if (scl_fall) state_d = mack_q ? S_RD_BYTE : S_IDLE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // datapath and byte events
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            txreg_q  <= '1;
            rw_q     <= 1'b0;
            first_q  <= 1'b0;
            mack_q   <= 1'b0;
            wr_ev    <= 1'b0;
            wr_first <= 1'b0;
            wr_data  <= '0;
            rd_ev    <= 1'b0;
        end else begin
            wr_ev <= 1'b0;
            rd_ev <= 1'b0;
            if (start_ev) begin
                bitcnt_q <= '0;
                first_q  <= 1'b1;
            end else begin
                if ((state_q == S_ADDR || state_q == S_WR_BYTE) && scl_rise) begin
                    shreg_q  <= {shreg_q[6:0], sda_s};
                    bitcnt_q <= bitcnt_q + 4'd1;
                end
                if (state_q == S_ADDR && state_d == S_ADDR_ACK) begin
                    rw_q    <= shreg_q[0];
                    first_q <= 1'b1;
                end
                if (state_q == S_WR_BYTE && state_d == S_WR_ACK) begin
                    wr_ev    <= 1'b1;
                    wr_data  <= shreg_q;
                    wr_first <= first_q;
                    first_q  <= 1'b0;
                end
                if (state_q != S_WR_BYTE && state_d == S_WR_BYTE) begin
                    bitcnt_q <= '0;
                end
                if (state_q != S_RD_BYTE && state_d == S_RD_BYTE) begin
                    txreg_q  <= tx_byte;
                    bitcnt_q <= '0;
                end
                if (state_q == S_RD_BYTE && state_d == S_RD_BYTE && scl_fall) begin
                    txreg_q  <= {txreg_q[6:0], 1'b1};
                    bitcnt_q <= bitcnt_q + 4'd1;
                end
                if (state_q == S_RD_BYTE && state_d == S_RD_ACK) begin
                    rd_ev  <= 1'b1;
                    mack_q <= 1'b0;
                end
                if (state_q == S_RD_ACK && scl_rise) begin
                    mack_q <= ~sda_s;
                end
            end
        end
    end

    // output logic
    always_comb begin
        unique case (state_q)
            S_ADDR_ACK, S_WR_ACK: sda_oe = 1'b1;
            S_RD_BYTE:            sda_oe = ~txreg_q[7];
            default:              sda_oe = 1'b0;
        endcase
    end

    // R11: a START always returns the engine to address reception
    a_r11_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state_q == S_ADDR));

    // R10: the line is never pulled while idle
    a_r10_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !sda_oe);

endmodule

// File: rtl/rtc_reg_file.sv
module rtc_reg_file
    import rtc_regif_pkg::*;
#(
    parameter int unsigned TIME_BYTES = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_ev,
    input  logic                    stop_ev,
    input  logic                    wr_ev,
    input  logic                    wr_first,
    input  logic [7:0]              wr_data,
    input  logic                    rd_ev,
    input  logic [8*TIME_BYTES-1:0] time_rd,
    input  logic                    osf_set,
    output logic [7:0]              tx_byte,
    output logic [TIME_BYTES-1:0]   time_ld,
    output logic [7:0]              time_wdata,
    output logic                    div_rst,
    output logic [7:0]              ctrl_q,
    output logic [7:0]              tcs_q
);

    localparam int unsigned PTR_W = 8;
    localparam logic [PTR_W-1:0] PTR_CTRL = PTR_W'(TIME_BYTES);
    localparam logic [PTR_W-1:0] PTR_TCS  = PTR_W'(TIME_BYTES + 1);
    localparam logic [PTR_W-1:0] PTR_FLAG = PTR_W'(TIME_BYTES + 2);

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        if (p == PTR_CTRL || p >= PTR_FLAG) return '0;
        return p + PTR_W'(1);
    endfunction

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_nxt;
    logic [7:0]       snap_q [TIME_BYTES];
    logic             osf_q;
    logic             wr_data_ev;
    logic             inc;
    logic             refresh;

    assign wr_data_ev = wr_ev & ~wr_first;
    assign inc        = rd_ev | wr_data_ev;
    assign ptr_nxt    = ptr_step(ptr_q);
    assign refresh    = start_ev | stop_ev | (inc && ptr_nxt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ptr_q <= '0;
        else if (wr_ev && wr_first) ptr_q <= wr_data;
        else if (inc)               ptr_q <= ptr_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TIME_BYTES; i++) snap_q[i] <= '0;
        end else if (refresh) begin
            for (int i = 0; i < TIME_BYTES; i++) snap_q[i] <= time_rd[8*i +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= CTRL_RESET;
            tcs_q      <= TCS_RESET;
            osf_q      <= 1'b1;
            div_rst    <= 1'b0;
            time_wdata <= '0;
        end else begin
            div_rst <= wr_data_ev && (ptr_q == '0 || ptr_q == PTR_CTRL);
            if (wr_data_ev && ptr_q < PTR_CTRL) time_wdata <= wr_data;
            if (wr_data_ev && ptr_q == PTR_CTRL) ctrl_q <= wr_data;
            if (wr_data_ev && ptr_q == PTR_TCS)  tcs_q  <= wr_data;
            if (osf_set)
                osf_q <= 1'b1;
            else if (wr_data_ev && ptr_q == PTR_FLAG && !wr_data[7])
                osf_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < TIME_BYTES; g++) begin : g_ld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) time_ld[g] <= 1'b0;
            else        time_ld[g] <= wr_data_ev && (ptr_q == PTR_W'(g));
        end
    end

    always_comb begin
        tx_byte = '0;
        for (int i = 0; i < TIME_BYTES; i++)
            if (ptr_q == PTR_W'(i)) tx_byte = snap_q[i];
        if (ptr_q == PTR_CTRL) tx_byte = ctrl_q;
        if (ptr_q == PTR_TCS)  tx_byte = tcs_q;
        if (ptr_q == PTR_FLAG) tx_byte = {osf_q, 7'b0};
    end

    // R5: at most one field strobe at a time
    a_r5_ld_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(time_ld));

    // R6: divider reset is a single-cycle pulse
    a_r6_divrst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |=> !div_rst);

    // R7: a stop report always leaves the flag set
    a_r7_osf_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        osf_set |=> osf_q);

    // R3: stepping past the control location returns to 00h
    a_r3_wrap_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !(wr_ev && wr_first) && ptr_q == PTR_CTRL) |=> (ptr_q == '0));

    // R4: snapshot holds without START, STOP or a pointer step
    a_r4_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ev && !stop_ev && !inc) |=> $stable(snap_q[0]));

endmodule

// File: rtl/rtc_i2c_regif.sv
module rtc_i2c_regif
    import rtc_regif_pkg::*;
#(
    parameter int unsigned TIME_BYTES  = 7,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [6:0]  SLV_ADDR    = 7'b1101000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    input  logic [8*TIME_BYTES-1:0] time_rd,
    input  logic                    osf_set,
    output logic [TIME_BYTES-1:0]   time_ld,
    output logic [7:0]              time_wdata,
    output logic                    div_rst,
    output logic                    out_level,
    output logic                    ft_en,
    output logic                    cal_sign,
    output logic [4:0]              cal_mag,
    output logic                    charger_en,
    output logic                    diode_sel,
    output logic [1:0]              res_sel
);

    logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic       wr_ev, wr_first, rd_ev;
    logic [7:0] wr_data, tx_byte, ctrl_q, tcs_q;
    logic       diode_ok;

    rtc_i2c_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    rtc_i2c_fsm #(.SLV_ADDR(SLV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev), .tx_byte(tx_byte),
        .sda_oe(sda_oe), .wr_ev(wr_ev), .wr_first(wr_first),
        .wr_data(wr_data), .rd_ev(rd_ev)
    );

    rtc_reg_file #(.TIME_BYTES(TIME_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
        .wr_ev(wr_ev), .wr_first(wr_first), .wr_data(wr_data), .rd_ev(rd_ev),
        .time_rd(time_rd), .osf_set(osf_set), .tx_byte(tx_byte),
        .time_ld(time_ld), .time_wdata(time_wdata), .div_rst(div_rst),
        .ctrl_q(ctrl_q), .tcs_q(tcs_q)
    );

    assign out_level = ctrl_q[7];
    assign ft_en     = ctrl_q[6];
    assign cal_sign  = ctrl_q[5];
    assign cal_mag   = ctrl_q[4:0];

    assign diode_ok   = (tcs_q[3:2] == 2'b01) || (tcs_q[3:2] == 2'b10);
    assign charger_en = (tcs_q[7:4] == CHARGE_KEY) && diode_ok && (tcs_q[1:0] != 2'b00);
    assign diode_sel  = charger_en && (tcs_q[3:2] == 2'b10);
    assign res_sel    = charger_en ? tcs_q[1:0] : 2'b00;

endmodule

// File: tb/rtc_i2c_regif_tb.sv
`timescale 1ns/1ps
module rtc_i2c_regif_tb;

    localparam logic [6:0] DEV = 7'b1101000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic [55:0] live = '0;
    logic        osf_set = 1'b0;
    logic [6:0]  time_ld;
    logic [7:0]  time_wdata;
    logic        div_rst, out_level, ft_en, cal_sign, charger_en, diode_sel;
    logic [4:0]  cal_mag;
    logic [1:0]  res_sel;
    wire         sda_bus = ~(m_low | sda_oe);

    always #2.5 clk = ~clk;

    rtc_i2c_regif u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .time_rd(live), .osf_set(osf_set), .time_ld(time_ld), .time_wdata(time_wdata),
        .div_rst(div_rst), .out_level(out_level), .ft_en(ft_en), .cal_sign(cal_sign),
        .cal_mag(cal_mag), .charger_en(charger_en), .diode_sel(diode_sel), .res_sel(res_sel)
    );

    int vec = 0, fails = 0;
    bit done = 0, cmp_en = 0;

    // behavioural reference state
    int         m_ptr = 0;
    logic [7:0] m_ctrl = 8'h80, m_tcs = 8'h00;
    logic       m_osf = 1'b1;
    logic [7:0] m_snap [7];
    int         exp_ld [7];
    logic [7:0] exp_ldv [7];
    int         exp_div = 0;
    int         ld_cnt [7];
    logic [7:0] ld_val [7];
    int         div_cnt = 0;
    logic [7:0] wbuf [8];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] chg_model(input logic [7:0] t);
        bit en;
        en = (t[7:4] == 4'hA) && (t[3:2] == 2'b01 || t[3:2] == 2'b10) && (t[1:0] != 0);
        return {en, en && t[3:2] == 2'b10, en ? t[1:0] : 2'b00};
    endfunction

    task automatic take_snap();
        for (int i = 0; i < 7; i++) m_snap[i] = live[8*i +: 8];
    endtask

    task automatic set_live(input logic [7:0] base);
        for (int i = 0; i < 7; i++) live[8*i +: 8] = base + 8'(i);
    endtask

    function automatic logic [7:0] m_expect();
        if (m_ptr < 7)  return m_snap[m_ptr];
        if (m_ptr == 7) return m_ctrl;
        if (m_ptr == 8) return m_tcs;
        if (m_ptr == 9) return {m_osf, 7'b0};
        return 8'h00;
    endfunction

    task automatic m_inc();
        m_ptr = (m_ptr == 7 || m_ptr >= 9) ? 0 : m_ptr + 1;
        if (m_ptr == 0) take_snap();
    endtask

    task automatic m_write(input logic [7:0] d);
        if (m_ptr < 7) begin
            exp_ld[m_ptr]++; exp_ldv[m_ptr] = d;
            if (m_ptr == 0) exp_div++;
        end else if (m_ptr == 7) begin
            m_ctrl = d; exp_div++;
        end else if (m_ptr == 8) m_tcs = d;
        else if (m_ptr == 9 && !d[7]) m_osf = 1'b0;
        m_inc();
    endtask

    // every-clock comparison against the reference while the bus is idle
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R9 ctrl outputs", {24'b0, out_level, ft_en, cal_sign, cal_mag}, {24'b0, m_ctrl});
            chk("R8 charger outputs", {28'b0, charger_en, diode_sel, res_sel}, {28'b0, chg_model(m_tcs)});
            chk("R10 idle release", {31'b0, sda_oe}, 32'd0);
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 7; i++)
                if (time_ld[i]) begin ld_cnt[i]++; ld_val[i] = time_wdata; end
            if (div_rst) div_cnt++;
        end
    end

    // bus primitives: quarter period 25 ns, SCL period 100 ns
    task automatic put_bit(input logic b);
        m_low = !b; #25; scl = 1'b1; #50; scl = 1'b0; #25;
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; #25; scl = 1'b1; #25; b = sda_bus; #25; scl = 1'b0; #25;
    endtask

    task automatic bus_start();
        m_low = 1'b0; #25; scl = 1'b1; #25; m_low = 1'b1; #25; scl = 1'b0; #25;
    endtask

    task automatic bus_stop();
        m_low = 1'b1; #25; scl = 1'b1; #25; m_low = 1'b0; #25;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(input bit last, output logic [7:0] b);
        logic bt;
        for (int i = 7; i >= 0; i--) begin get_bit(bt); b[i] = bt; end
        put_bit(last);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] p, input int n, input string tag);
        bit ack, match;
        match = (a == DEV);
        cmp_en = 0;
        bus_start(); take_snap();
        send_byte({a, 1'b0}, ack);
        chk({tag, " R1 address ack"}, {31'b0, ack}, {31'b0, match});
        send_byte(p, ack);
        chk({tag, " R2 pointer byte ack"}, {31'b0, ack}, {31'b0, match});
        if (match) m_ptr = p;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk({tag, " R1 data ack"}, {31'b0, ack}, {31'b0, match});
            if (match) m_write(wbuf[i]);
        end
        bus_stop(); take_snap(); #50;
        for (int i = 0; i < 7; i++) begin
            chk({tag, " R5 strobe count"}, ld_cnt[i], exp_ld[i]);
            if (exp_ld[i] > 0) chk({tag, " R5 strobe data"}, {24'b0, ld_val[i]}, {24'b0, exp_ldv[i]});
        end
        chk({tag, " R6 divider resets"}, div_cnt, exp_div);
        cmp_en = 1;
    endtask

    task automatic do_read(input int n, input string tag, input int change_at);
        bit ack;
        logic [7:0] b;
        cmp_en = 0;
        bus_start(); take_snap();
        send_byte({DEV, 1'b1}, ack);
        chk({tag, " R1 read address ack"}, {31'b0, ack}, 32'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            chk({tag, " read byte"}, {24'b0, b}, {24'b0, m_expect()});
            m_inc();
            if (i == change_at) set_live(8'h40);
        end
        #50;
        chk({tag, " R10 released after NACK"}, {31'b0, sda_oe}, 32'd0);
        bus_stop(); take_snap(); #50;
        cmp_en = 1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog R11 act=hung exp=complete");
            finish_run();
        end
    end

    initial begin
        logic [7:0] pat [7];
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin exp_ld[i] = 0; ld_cnt[i] = 0; exp_ldv[i] = 0; ld_val[i] = 0; end
        set_live(8'h10); take_snap();
        #51;
        rst_n = 1'b1;
        #50;
        chk("R9 reset out_level", {31'b0, out_level}, 32'd1);
        chk("R8 reset charger off", {31'b0, charger_en}, 32'd0);
        chk("R10 reset released", {31'b0, sda_oe}, 32'd0);
        cmp_en = 1;

        // R3 R7 R8: charger and flag reached by pointer load, then wrap 09h->00h
        do_write(DEV, 8'h08, 0, "R3 load 08h");
        do_read(3, "R3 08h 09h wrap", -1);

        // R4: block read from 00h, live time changes mid read, rollover refresh
        do_write(DEV, 8'h00, 0, "R4 ptr 00h");
        do_read(9, "R4 snapshot", 5);

        // R2: pointer retained between reads
        do_write(DEV, 8'h02, 0, "R2 ptr 02h");
        do_read(2, "R2 first read", -1);
        do_read(1, "R2 continued read", -1);

        // R5 R6: time field writes
        wbuf[0] = 8'h30; wbuf[1] = 8'h31; wbuf[2] = 8'h32;
        do_write(DEV, 8'h00, 3, "R5 time fields");

        // R6 R9 R3: control write then wrap 07h->00h on a write
        wbuf[0] = 8'h6A; wbuf[1] = 8'h55;
        do_write(DEV, 8'h07, 2, "R6 control");
        do_write(DEV, 8'h07, 0, "R9 ptr 07h");
        do_read(1, "R9 control readback", -1);

        // R8: charger patterns
        pat[0] = 8'hA5; pat[1] = 8'hAA; pat[2] = 8'hAB; pat[3] = 8'hA8;
        pat[4] = 8'hAD; pat[5] = 8'hA1; pat[6] = 8'h5A;
        for (int k = 0; k < 7; k++) begin
            wbuf[0] = pat[k];
            do_write(DEV, 8'h08, 1, "R8 pattern");
            chk("R8 charger_en", {31'b0, charger_en}, {31'b0, chg_model(pat[k])[3]});
            chk("R8 diode/res", {29'b0, diode_sel, res_sel}, {29'b0, chg_model(pat[k])[2:0]});
        end

        // R7: flag write-one ignored, write-zero clears, detector sets
        wbuf[0] = 8'hFF;
        do_write(DEV, 8'h09, 1, "R7 write ones");
        do_write(DEV, 8'h09, 0, "R7 ptr 09h");
        do_read(1, "R7 flag kept", -1);
        wbuf[0] = 8'h00;
        do_write(DEV, 8'h09, 1, "R7 clear");
        do_write(DEV, 8'h09, 0, "R7 ptr 09h");
        do_read(1, "R7 flag cleared", -1);
        @(negedge clk) osf_set = 1'b1;
        @(negedge clk) osf_set = 1'b0;
        m_osf = 1'b1;
        do_write(DEV, 8'h09, 0, "R7 ptr 09h");
        do_read(1, "R7 flag set", -1);

        // R1: foreign address ignored
        wbuf[0] = 8'h00;
        do_write(7'h50, 8'h07, 1, "R1 foreign");
        chk("R1 control untouched", {31'b0, ft_en}, {31'b0, m_ctrl[6]});

        // R11: repeated START from write into read
        cmp_en = 0;
        bus_start(); take_snap();
        send_byte({DEV, 1'b0}, ack);
        chk("R11 address ack", {31'b0, ack}, 32'd1);
        send_byte(8'h08, ack);
        m_ptr = 8;
        bus_start(); take_snap();
        send_byte({DEV, 1'b1}, ack);
        chk("R11 restart ack", {31'b0, ack}, 32'd1);
        recv_byte(1'b1, b);
        chk("R11 read after restart", {24'b0, b}, {24'b0, m_expect()});
        m_inc();
        bus_stop(); take_snap(); #50;
        cmp_en = 1;

        // R3: out-of-range pointer reads 00h and wraps to 00h
        set_live(8'h70);
        do_write(DEV, 8'h0C, 0, "R3 ptr 0Ch");
        do_read(2, "R3 out of range", -1);

        #200;
        done = 1;
        finish_run();
    end

endmodule